// File: doc/BRIEF.md
# Shared Video Interrupt Latch and Enable Unit

This block holds the interrupt bookkeeping shared by a video controller's native interrupt sources and a display-list coprocessor. Each source delivers a one-cycle request pulse, and that pulse sets its pending bit in a latch register. A companion enable register chooses which pending bits may pull down a single active-low, level-sensitive interrupt line to the CPU. The coprocessor uses bit 4 of both registers. Bits 0 to 3 belong to the native sources, in this order: raster, sprite-to-background collision, sprite-to-sprite collision and light pen.

Software reads and writes the two registers over a plain register bus. A handler reads the latch register to find out which source raised the interrupt. It then acknowledges that source by writing a one to the matching bit. If the handler does not acknowledge the bit, the line stays low and the interrupt is taken again as soon as the handler returns. The source count and the register offsets are parameters. The default build has five sources, the latch register at offset 0x19 and the enable register at offset 0x1A.

Top module: `vidirq_unit`

## Requirements
- R1: After reset, every pending bit and every enable bit is 0 and `irq_n` is 1.
- R2: A 1 on `src_req[i]` in a cycle sets pending bit i at that clock edge. The bit stays set until it is acknowledged. The enable bits do not affect this.
- R3: A bus write to offset 0x19 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are left unchanged.
- R4: If a request for bit i arrives in the same cycle as an acknowledge write of bit i, pending bit i ends up set.
- R5: A bus write to offset 0x1A loads data bits 4:0 into the enable register. Bit 4 is the coprocessor enable. A write to the enable register never changes any pending bit.
- R6: `irq_n` is a register. After each clock edge it is 0 if some bit was both pending and enabled before that edge, and 1 otherwise. It therefore follows a change of the pending or enable bits one cycle later.
- R7: While a pending and enabled bit is left unacknowledged, `irq_n` stays 0 on every cycle (level retrigger).
- R8: A read at offset 0x19 returns the pending bits in 4:0 and ones in 6:5. Bit 7 is the OR of all bits that are both pending and enabled at that moment.
- R9: A read at offset 0x1A returns the enable bits in 4:0 and ones in 7:5.
- R10: A read at any other offset returns 0x00. A write to any other offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for the current `bus_addr`, combinational |
| src_req | input | 5 | Request pulses; bit 4 is the coprocessor, bits 3:0 are the native sources |
| irq_n | output | 1 | Active-low level interrupt line |

## Verification
The assertions assume that every input is a known value on each clock edge while reset is released. They also assume that a write strobe lasts exactly one cycle for each intended write, because a strobe held high would apply the write again on every edge. The bench drives every input on the falling edge and holds it through the following rising edge. In its random phase it keeps requests sparse, so that acknowledges, collisions and idle spans all occur. It sends writes to the two register offsets and to one unused offset.

// File: rtl/vidirq_pkg.sv
package vidirq_pkg;
   localparam int DATA_W = 8;
   typedef struct packed {
      logic latch_hit;
      logic mask_hit;
   } reg_sel_t;
endpackage

// File: rtl/vidirq_decode.sv
module vidirq_decode #(
   parameter int ADDR_W    = 6,
   parameter int LATCH_OFS = 'h19,
   parameter int MASK_OFS  = 'h1A
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  we,
   output vidirq_pkg::reg_sel_t  rd_sel,
   output vidirq_pkg::reg_sel_t  wr_sel
);
   localparam logic [ADDR_W-1:0] LATCH_A = ADDR_W'(LATCH_OFS);
   localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(MASK_OFS);

   if (LATCH_OFS == MASK_OFS) begin : g_bad_ofs
      $error("vidirq_decode: latch and mask offsets must differ");
   end
   if (LATCH_OFS >= (1 << ADDR_W) || MASK_OFS >= (1 << ADDR_W)) begin : g_bad_width
      $error("vidirq_decode: offset does not fit in ADDR_W");
   end

   always_comb begin
      rd_sel.latch_hit = (addr == LATCH_A);
      rd_sel.mask_hit  = (addr == MASK_A);
      wr_sel.latch_hit = we && rd_sel.latch_hit;
      wr_sel.mask_hit  = we && rd_sel.mask_hit;
   end
endmodule

// File: rtl/vidirq_latch.sv
module vidirq_latch #(
   parameter int NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               ack_we,
   input  logic [NUM_SRC-1:0] ack_bits,
   output logic [NUM_SRC-1:0] pend_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic ack_i;
      assign ack_i = ack_we && ack_bits[i];

      always_ff @(posedge clk) begin
         if (!rst_n)          pend_q[i] <= 1'b0;
         else if (src_req[i]) pend_q[i] <= 1'b1;
         else if (ack_i)      pend_q[i] <= 1'b0;
      end

      p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
         src_req[i] |=> pend_q[i]);
      p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_we && ack_bits[i] && !src_req[i]) |=> !pend_q[i]);
      p_zero_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!src_req[i] && !(ack_we && ack_bits[i])) |=> $stable(pend_q[i]));
      p_req_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_we && ack_bits[i] && src_req[i]) |=> pend_q[i]);
   end
endmodule

// File: rtl/vidirq_mask.sv
module vidirq_mask #(
   parameter int NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [NUM_SRC-1:0] load_bits,
   output logic [NUM_SRC-1:0] en_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    en_q <= '0;
      else if (load) en_q <= load_bits;
   end

   p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (en_q == $past(load_bits)));
   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(en_q));
endmodule

// File: rtl/vidirq_line.sv
module vidirq_line #(
   parameter int NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] en,
   output logic               irq_n
);
   logic live;
   assign live = |(pend & en);

   always_ff @(posedge clk) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= ~live;
   end

   p_irq_assert_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend & en)) |=> !irq_n);
   p_irq_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(pend & en)) |=> irq_n);
   p_irq_retrig_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && (|(pend & en))) |=> !irq_n);
endmodule

// File: rtl/vidirq_unit.sv
module vidirq_unit #(
   parameter int ADDR_W    = 6,
   parameter int NUM_SRC   = 5,
   parameter int LATCH_OFS = 'h19,
   parameter int MASK_OFS  = 'h1A
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [7:0]         bus_wdata,
   input  logic               bus_we,
   output logic [7:0]         bus_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   output logic               irq_n
);
   import vidirq_pkg::*;

   if (NUM_SRC < 1 || NUM_SRC > DATA_W - 1) begin : g_bad_src
      $error("vidirq_unit: NUM_SRC must leave bit 7 free for the summary flag");
   end

   reg_sel_t           rd_sel, wr_sel;
   logic [NUM_SRC-1:0] pend, en;
   logic [7:0]         latch_view, mask_view;
   logic               unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata;

   vidirq_decode #(.ADDR_W(ADDR_W), .LATCH_OFS(LATCH_OFS), .MASK_OFS(MASK_OFS)) u_dec (
      .addr(bus_addr), .we(bus_we), .rd_sel(rd_sel), .wr_sel(wr_sel));

   vidirq_latch #(.NUM_SRC(NUM_SRC)) u_lat (
      .clk(clk), .rst_n(rst_n), .src_req(src_req),
      .ack_we(wr_sel.latch_hit), .ack_bits(bus_wdata[NUM_SRC-1:0]), .pend_q(pend));

   vidirq_mask #(.NUM_SRC(NUM_SRC)) u_msk (
      .clk(clk), .rst_n(rst_n), .load(wr_sel.mask_hit),
      .load_bits(bus_wdata[NUM_SRC-1:0]), .en_q(en));

   vidirq_line #(.NUM_SRC(NUM_SRC)) u_line (
      .clk(clk), .rst_n(rst_n), .pend(pend), .en(en), .irq_n(irq_n));

   for (genvar b = 0; b < 7; b++) begin : g_view
      if (b < NUM_SRC) begin : g_src
         assign latch_view[b] = pend[b];
         assign mask_view[b]  = en[b];
      end else begin : g_pad
         assign latch_view[b] = 1'b1;
         assign mask_view[b]  = 1'b1;
      end
   end
   assign latch_view[7] = |(pend & en);
   assign mask_view[7]  = 1'b1;

   always_comb begin
      if (rd_sel.latch_hit)     bus_rdata = latch_view;
      else if (rd_sel.mask_hit) bus_rdata = mask_view;
      else                      bus_rdata = 8'h00;
   end

   p_other_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_sel.latch_hit && !rd_sel.mask_hit) |-> (bus_rdata == 8'h00));
   p_other_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !rd_sel.latch_hit && !rd_sel.mask_hit && src_req == '0)
      |=> ($stable(pend) && $stable(en)));
endmodule

// File: tb/sim_vidirq_unit.sv
`timescale 1ns/1ps
module sim_vidirq_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] bus_addr = 6'h19;
   logic [7:0] bus_wdata = 8'h00;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic [4:0] src_req = 5'h0;
   logic       irq_n;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   string tag = "R1";

   // reference model state
   int m_lat = 0, m_msk = 0, m_irq = 1;

   always #2.5 clk = ~clk;

   vidirq_unit u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                   .bus_we(bus_we), .bus_rdata(bus_rdata), .src_req(src_req), .irq_n(irq_n));

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lat <= 0; m_msk <= 0; m_irq <= 1;
      end else begin
         int nl;
         nl = m_lat;
         if (bus_we && bus_addr == 6'h19) nl = nl & ~int'(bus_wdata[4:0]);
         nl = nl | int'(src_req);
         m_irq <= ((m_lat & m_msk) != 0) ? 0 : 1;
         m_lat <= nl;
         if (bus_we && bus_addr == 6'h1A) m_msk <= int'(bus_wdata[4:0]);
      end
   end

   function automatic int exp_rd();
      if (bus_addr == 6'h19) return (((m_lat & m_msk) != 0) ? 'h80 : 0) | 'h60 | m_lat;
      if (bus_addr == 6'h1A) return 'hE0 | m_msk;
      return 0;
   endfunction

   task automatic chk(input string r, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", r, act, exp, $time);
      end
   endtask

   task automatic cmp_model();
      chk({tag, " rdata"}, int'(bus_rdata), exp_rd());
      chk({tag, " irq_n"}, int'(irq_n), m_irq);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      if (rst_n) cmp_model();
   endtask

   task automatic idle();
      bus_we = 0; src_req = 0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d, input logic [4:0] rq);
      bus_addr = a; bus_wdata = d; bus_we = 1; src_req = rq;
      tick();
      idle();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      bus_addr = 6'h19;
      #0.1;
      chk("R1 latch view", int'(bus_rdata), 'h60);
      chk("R1 irq_n", int'(irq_n), 1);
      bus_addr = 6'h1A; #0.1;
      chk("R1 mask view", int'(bus_rdata), 'hE0);
      bus_addr = 6'h19;

      // R2, R11-style: request while masked latches, no interrupt
      tag = "R2";
      src_req = 5'h10; tick(); idle();
      chk("R2 coproc pending while masked", int'(bus_rdata), 'h70);
      tick();
      chk("R2 holds, irq idle", int'(irq_n), 1);

      // R5 + R6: enable coprocessor, irq one cycle later
      tag = "R6";
      wr(6'h1A, 8'h10, 5'h0);
      bus_addr = 6'h19; #0.1;
      chk("R8 summary bit set", int'(bus_rdata), 'hF0);
      chk("R6 irq not yet", int'(irq_n), 1);
      tick();
      chk("R6 irq low after one cycle", int'(irq_n), 0);

      // R7: level retrigger
      tag = "R7";
      repeat (5) tick();
      chk("R7 still low", int'(irq_n), 0);

      // R3: zeros leave the bit
      tag = "R3";
      wr(6'h19, 8'h0F, 5'h0);
      chk("R3 zero keeps bit4", int'(bus_rdata), 'hF0);

      // R4: request with ack keeps bit
      tag = "R4";
      wr(6'h19, 8'h10, 5'h10);
      chk("R4 request wins", int'(bus_rdata), 'hF0);

      // R3: ack clears, R6 irq releases a cycle later
      tag = "R3";
      wr(6'h19, 8'h10, 5'h0);
      chk("R3 ack clears", int'(bus_rdata), 'h60);
      chk("R6 irq lags clear", int'(irq_n), 0);
      tick();
      chk("R6 irq released", int'(irq_n), 1);

      // R5: mask write leaves pending bits; R9 readback
      tag = "R5";
      src_req = 5'h05; tick(); idle();
      wr(6'h1A, 8'h1F, 5'h0);
      chk("R9 mask view", int'(bus_rdata), 'hFF);
      bus_addr = 6'h19; #0.1;
      chk("R5 pending kept by mask write", int'(bus_rdata), 'hE5);

      // R10: other address
      tag = "R10";
      wr(6'h05, 8'hFF, 5'h0);
      chk("R10 other reads zero", int'(bus_rdata), 0);
      bus_addr = 6'h19; #0.1;
      chk("R10 state unchanged", int'(bus_rdata), 'hE5);
      wr(6'h19, 8'h1F, 5'h0);

      // random phase against the model
      tag = "R8";
      for (int k = 0; k < 400; k++) begin
         int sel;
         sel = int'($urandom_range(0, 2));
         bus_addr = (sel == 0) ? 6'h19 : (sel == 1) ? 6'h1A : 6'h05;
         bus_wdata = 8'($urandom);
         bus_we = ($urandom_range(0, 2) == 0);
         src_req = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'h0;
         tick();
      end
      idle();
      tick();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule